// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Status Registers

This block is the software-visible control and status register file for a DMA engine with up to eight channels. It sits on a simple single-cycle 32-bit register bus. A control word packs a configuration slice for each channel: a 2-bit transfer mode and a direction bit, 4 bits per channel. The slices drive the channel datapaths directly. A second word holds one interrupt enable bit per channel.

The channel datapaths report completion and error pulses, and present their live 2-bit activity state, through dedicated ports. Completion and error pulses are captured in sticky flags, and an error always raises the channel's interrupt flag as well. Software reads the status word, handles the channels, and writes the same value back to clear exactly the flags it saw. A single interrupt line is asserted while any enabled channel has a pending flag.

Reads are combinational. `rdata_o` shows the addressed word while `req_i` is high and `we_i` is low, and is zero at all other times. Writes take effect at the clock edge on which `req_i` and `we_i` are both high.

Top module: `dma_csr_top`

## Requirements
- R1: After reset the control word, the enable word, and all interrupt and error flags are zero, and `irq_o` is low.
- R2: The control word at offset 0x00 stores, for channel n, bits 4n+2..4n. Bits 4n+1..4n are the mode and bit 4n+2 is the direction. Bit 4n+3 always reads 0. `ch_cfg_o` carries the stored word.
- R3: The enable word at offset 0x08 stores bit n as channel n's interrupt enable. Bits 31..8 read 0.
- R4: A pulse on `done_i[n]` sets interrupt flag n, which reads at bit n of offset 0x10. The flag stays set until software clears it.
- R5: A pulse on `err_i[n]` sets both error flag n (bit n+8 of offset 0x10) and interrupt flag n.
- R6: A write to offset 0x10 clears each interrupt or error flag whose bit in the write data is 1. Flags whose write bit is 0 are unchanged.
- R7: When an event for a flag arrives in the same cycle as a write that clears that flag, the flag ends up set.
- R8: Bits 16+2n+1..16+2n of offset 0x10 show `state_i[2n+1:2n]` live. Writes to these bits have no effect.
- R9: `irq_o` is high exactly when some channel has its interrupt flag set and its enable bit set.
- R10: Reads of any offset other than 0x00, 0x08 and 0x10 return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when not reading |
| done_i | input | NCH | Per-channel completion pulse |
| err_i | input | NCH | Per-channel error pulse |
| state_i | input | 2*NCH | Per-channel live 2-bit state |
| ch_cfg_o | output | 4*NCH | Per-channel mode and direction slices |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle, the bound checker verifies the following behaviours:
- a completion or error pulse is followed by a set flag, which covers the case where an event and a clear collide;
- an untouched flag holds its value;
- a clear with no competing event removes the flag;
- the line stays quiet when no enable bit is set;
- unmapped reads return zero and status reads mirror the live state.

Other properties depend on values that only a sequence of bus accesses can reveal, so the bench scenarios demonstrate them:
- the exact packing and masking of the control slices;
- the zero upper bits of the enable word;
- that a write-back of a read value clears only the flags that were seen;
- that writes to unmapped offsets leave the real registers untouched.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned AW        = 8;
  localparam int unsigned DW        = 32;
  localparam int unsigned SLICE_W   = 4;
  localparam int unsigned ERR_LSB   = 8;
  localparam int unsigned STATE_LSB = 16;
  localparam int unsigned STATE_W   = 2;
  localparam logic [AW-1:0] OFF_CTRL = 8'h00;
  localparam logic [AW-1:0] OFF_IEN  = 8'h08;
  localparam logic [AW-1:0] OFF_STAT = 8'h10;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl #(
  parameter int unsigned NCH = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   wr_ctrl_i,
  input  logic                                   wr_ien_i,
  input  logic [dma_csr_pkg::SLICE_W*NCH-1:0]    ctrl_wdata_i,
  input  logic [NCH-1:0]                         ien_wdata_i,
  output logic [dma_csr_pkg::SLICE_W*NCH-1:0]    ctrl_q_o,
  output logic [NCH-1:0]                         ien_q_o
);
  localparam int unsigned CW = dma_csr_pkg::SLICE_W * NCH;

  logic [CW-1:0] slice_mask;

  // mode (2 bits) + direction (1 bit) kept per slice; top bit reserved
  for (genvar n = 0; n < NCH; n++) begin : g_mask
    assign slice_mask[n*dma_csr_pkg::SLICE_W +: dma_csr_pkg::SLICE_W] = 4'b0111;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q_o <= '0;
      ien_q_o  <= '0;
    end else begin
      if (wr_ctrl_i) ctrl_q_o <= ctrl_wdata_i & slice_mask;
      if (wr_ien_i)  ien_q_o  <= ien_wdata_i;
    end
  end
endmodule

// File: rtl/dma_csr_flags.sv
module dma_csr_flags #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] err_i,
  input  logic [NCH-1:0] clr_irq_i,
  input  logic [NCH-1:0] clr_err_i,
  output logic [NCH-1:0] irq_q_o,
  output logic [NCH-1:0] err_q_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic set_irq;
    assign set_irq = done_i[n] | err_i[n];

    // set dominates clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q_o[n] <= 1'b0;
        err_q_o[n] <= 1'b0;
      end else begin
        irq_q_o[n] <= set_irq  | (irq_q_o[n] & ~clr_irq_i[n]);
        err_q_o[n] <= err_i[n] | (err_q_o[n] & ~clr_err_i[n]);
      end
    end
  end
endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux #(
  parameter int unsigned NCH = 8
) (
  input  logic                                   rd_i,
  input  logic [dma_csr_pkg::AW-1:0]             addr_i,
  input  logic [dma_csr_pkg::SLICE_W*NCH-1:0]    ctrl_i,
  input  logic [NCH-1:0]                         ien_i,
  input  logic [NCH-1:0]                         irq_i,
  input  logic [NCH-1:0]                         err_i,
  input  logic [dma_csr_pkg::STATE_W*NCH-1:0]    state_i,
  output logic [dma_csr_pkg::DW-1:0]             rdata_o
);
  import dma_csr_pkg::*;

  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[NCH-1:0]                        = irq_i;
    stat_word[ERR_LSB +: NCH]                 = err_i;
    stat_word[STATE_LSB +: STATE_W*NCH]       = state_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFF_CTRL: rdata_o[SLICE_W*NCH-1:0] = ctrl_i;
        OFF_IEN:  rdata_o[NCH-1:0]         = ien_i;
        OFF_STAT: rdata_o                  = stat_word;
        default:  rdata_o                  = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top #(
  parameter int unsigned NCH = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic [7:0]                          addr_i,
  input  logic [31:0]                         wdata_i,
  output logic [31:0]                         rdata_o,
  input  logic [NCH-1:0]                      done_i,
  input  logic [NCH-1:0]                      err_i,
  input  logic [2*NCH-1:0]                    state_i,
  output logic [4*NCH-1:0]                    ch_cfg_o,
  output logic                                irq_o
);
  import dma_csr_pkg::*;

  logic           wr_en, rd_en;
  logic           wr_stat;
  logic [NCH-1:0] irq_flags, err_flags, irq_en;
  logic [NCH-1:0] clr_irq, clr_err;

  assign wr_en   = req_i & we_i;
  assign rd_en   = req_i & ~we_i;
  assign wr_stat = wr_en && (addr_i == OFF_STAT);
  assign clr_irq = wr_stat ? wdata_i[NCH-1:0]       : '0;
  assign clr_err = wr_stat ? wdata_i[ERR_LSB +: NCH] : '0;

  dma_csr_ctrl #(.NCH(NCH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr_en && (addr_i == OFF_CTRL)),
    .wr_ien_i    (wr_en && (addr_i == OFF_IEN)),
    .ctrl_wdata_i(wdata_i[SLICE_W*NCH-1:0]),
    .ien_wdata_i (wdata_i[NCH-1:0]),
    .ctrl_q_o    (ch_cfg_o),
    .ien_q_o     (irq_en)
  );

  dma_csr_flags #(.NCH(NCH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done_i),
    .err_i    (err_i),
    .clr_irq_i(clr_irq),
    .clr_err_i(clr_err),
    .irq_q_o  (irq_flags),
    .err_q_o  (err_flags)
  );

  dma_csr_rdmux #(.NCH(NCH)) u_rdmux (
    .rd_i   (rd_en),
    .addr_i (addr_i),
    .ctrl_i (ch_cfg_o),
    .ien_i  (irq_en),
    .irq_i  (irq_flags),
    .err_i  (err_flags),
    .state_i(state_i),
    .rdata_o(rdata_o)
  );

  assign irq_o = |(irq_flags & irq_en);
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
  parameter int unsigned NCH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [7:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic [NCH-1:0]   done_i,
  input logic [NCH-1:0]   err_i,
  input logic [2*NCH-1:0] state_i,
  input logic [NCH-1:0]   irq_flags,
  input logic [NCH-1:0]   err_flags,
  input logic [NCH-1:0]   irq_en,
  input logic             irq_o
);
  logic stat_wr, unmapped_rd;
  assign stat_wr     = req_i && we_i && (addr_i == 8'h10);
  assign unmapped_rd = req_i && !we_i && (addr_i != 8'h00) && (addr_i != 8'h08) && (addr_i != 8'h10);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // R4, R7
    p_done_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[n] |=> irq_flags[n]);
    // R5
    p_err_sets_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i[n] |=> (irq_flags[n] && err_flags[n]));
    // R6
    p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_flags[n] && stat_wr && wdata_i[n] && !done_i[n] && !err_i[n]) |=> !irq_flags[n]);
    // R4
    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_flags[n] && !(stat_wr && wdata_i[n])) |=> irq_flags[n]);
  end

  // R9
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en == '0) |-> !irq_o);
  // R10
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_rd |-> (rdata_o == 32'h0));
  // R8
  p_state_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 8'h10) |-> (rdata_o[16 +: 2*NCH] == state_i));
endmodule

bind dma_csr_top dma_csr_chk #(.NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .done_i   (done_i),
  .err_i    (err_i),
  .state_i  (state_i),
  .irq_flags(irq_flags),
  .err_flags(err_flags),
  .irq_en   (irq_en),
  .irq_o    (irq_o)
);

// File: tb/dma_csr_top_tb_top.sv
`timescale 1ns/100ps
module dma_csr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  done = '0, err = '0;
  logic [15:0] state = 16'hA5C3;
  logic [31:0] cfg;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          finished = 0;

  always #2 clk = ~clk;

  dma_csr_top #(.NCH(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_i(done), .err_i(err),
    .state_i(state), .ch_cfg_o(cfg), .irq_o(irq)
  );

  task automatic check(input string tg, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tg, got, exp);
    end
  endtask

  task automatic op(input string tg, input logic rq, input logic w, input logic [7:0] a,
                    input logic [31:0] d, input logic [7:0] dn, input logic [7:0] er,
                    input logic [31:0] exp);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; done = dn; err = er;
    if (rq && !w) begin
      exp_q.push_back(exp);
      tag_q.push_back(tg);
    end
    @(posedge clk); #1;
    req = 0; we = 0; done = '0; err = '0;
  endtask

  task automatic rd(input string tg, input logic [7:0] a, input logic [31:0] exp);
    op(tg, 1, 0, a, 32'h0, 8'h0, 8'h0, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    op("", 1, 1, a, d, 8'h0, 8'h0, 32'h0);
  endtask

  task automatic ev(input logic [7:0] dn, input logic [7:0] er);
    op("", 0, 0, 8'h0, 32'h0, dn, er, 32'h0);
  endtask

  // monitor: pops expected read data as each read is presented
  initial forever begin
    @(negedge clk); #1;
    if (req && !we) begin
      if (exp_q.size() == 0) check("monitor underflow", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    check("R1 irq_o after reset", {31'b0, irq}, 32'h0);
    check("R1 ch_cfg_o after reset", cfg, 32'h0);
    rd("R1 ctrl reset", 8'h00, 32'h0);
    rd("R1 ien reset", 8'h08, 32'h0);
    rd("R1 stat reset", 8'h10, 32'hA5C3_0000);
    // R2
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R2 ctrl all ones masked", 8'h00, 32'h7777_7777);
    check("R2 ch_cfg_o", cfg, 32'h7777_7777);
    wr(8'h00, 32'h1234_5678);
    rd("R2 ctrl pattern", 8'h00, 32'h1234_5670);
    // R3
    wr(8'h08, 32'hFFFF_FF5A);
    rd("R3 ien upper zero", 8'h08, 32'h0000_005A);
    // R4 / R9
    ev(8'h01, 8'h00);
    check("R9 disabled ch0 keeps irq low", {31'b0, irq}, 32'h0);
    rd("R4 done ch0", 8'h10, 32'hA5C3_0001);
    ev(8'h02, 8'h00);
    check("R9 enabled ch1 raises irq", {31'b0, irq}, 32'h1);
    rd("R4 done ch1", 8'h10, 32'hA5C3_0003);
    ev(8'h00, 8'h00);
    rd("R4 sticky", 8'h10, 32'hA5C3_0003);
    // R5
    ev(8'h00, 8'h04);
    rd("R5 err ch2 sets both", 8'h10, 32'hA5C3_0407);
    // R6 / R8: clear bits 0 and 10, try to write the state field
    wr(8'h10, 32'hFFFF_0401);
    rd("R6 R8 partial w1c", 8'h10, 32'hA5C3_0006);
    // R7
    op("", 1, 1, 8'h10, 32'h0000_0002, 8'h02, 8'h00, 32'h0);
    rd("R7 event beats clear", 8'h10, 32'hA5C3_0006);
    // R6
    wr(8'h10, 32'h0000_FFFF);
    rd("R6 clear all", 8'h10, 32'hA5C3_0000);
    check("R6 irq low after clear", {31'b0, irq}, 32'h0);
    // R10
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd("R10 ctrl untouched", 8'h00, 32'h1234_5670);
    rd("R10 ien untouched", 8'h08, 32'h0000_005A);
    rd("R10 stat untouched", 8'h10, 32'hA5C3_0000);
    rd("R10 read 0x04", 8'h04, 32'h0);
    rd("R10 read 0x0C", 8'h0C, 32'h0);
    rd("R10 read 0x14", 8'h14, 32'h0);
    // R9
    ev(8'h80, 8'h00);
    check("R9 ch7 disabled", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h0000_0080);
    check("R9 ch7 enabled", {31'b0, irq}, 32'h1);
    // R8 live mirror
    @(negedge clk); state = 16'h1E2D;
    rd("R8 live state", 8'h10, 32'h1E2D_0080);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule